// File: doc/BRIEF.md
# AUX Native Transfer Sequencer

The sequencer takes a native register access of any length (a read or a write of up to 2^LEN_W-1 bytes at a 20-bit register address) and turns it into a series of bounded requests to a lower-level AUX channel engine. Each request carries at most 16 bytes. The sequencer retries every request that fails, up to a fixed number of attempts. It returns the read bytes to the client one at a time, followed by a single done or error pulse.

The client starts a transfer with a one-cycle `start_i`. Write bytes are fetched combinationally through a byte-offset pointer. Read bytes come back with a valid strobe and their offset within the transfer. On the engine side the block does the following for each attempt:
- clears the engine data buffer;
- presents the address as low, middle and high fields and the command word;
- fills the buffer for writes;
- pulses a launch strobe;
- watches the engine's self-clearing enable bit, its reply-received flag, its access-error flag and its reply-status field.

Millisecond timeouts come from a free-running tick prescaler. A failed attempt is classified as an enable timeout, a reply timeout or a reply/access error.

Top module: `aux_xfer_seq`

## Requirements
- R1: A transfer is issued as chunks of min(remaining,16) bytes. After each successful chunk, the address presented to the engine and the byte offset advance by that chunk's size.
- R2: A chunk is launched at most 10 times. When the tenth attempt fails, `err_o` pulses, `busy_o` drops and no later chunk is launched.
- R3: Every launch is preceded by a `buf_clr_o` pulse within the same attempt. Address bits 7:0, 15:8 and 19:16 appear on `addr_lo_o`, `addr_mid_o` and `addr_hi_o`.
- R4: The command word `cmd_o` holds the byte count minus one in bits 7:4, has bit 3 set (native access), bits 2:1 clear, and bit 0 set for a read and clear for a write.
- R5: For a write, the chunk's bytes are written into buffer slots 0..n-1 before launch, and slot k holds client byte (chunk offset + k).
- R6: For a read, bytes are delivered on `rd_vld_o` only after an attempt succeeds, exactly once per transferred byte, with `rd_idx_o` equal to the byte's offset in the transfer.
- R7: If the engine enable bit stays set for EN_TMO ticks after launch, the attempt fails, and `err_code_o` = 1 if it was the last attempt.
- R8: If no reply-received flag arrives within RPLY_TMO ticks, the attempt fails with code 2. A received reply is acknowledged by a `reply_clr_o` pulse while the flag is set.
- R9: If the access-error flag is set after a reply, `acc_err_clr_o` pulses and the attempt fails with code 3. A nonzero reply-status field also fails the attempt with code 3.
- R10: A start with zero length pulses `done_o` in the next cycle and launches nothing.
- R11: After reset, `busy_o`, `done_o`, `err_o` and `launch_o` are low. While idle, no launch and no read strobe occur.
- R12: `done_o` and `err_o` are never high together, and each is seen only with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 20 | Starting register address |
| len_i | input | LEN_W | Byte count |
| wdata_i | input | 8 | Write byte at offset `wbyte_idx_o` |
| wbyte_idx_o | output | LEN_W | Offset of the write byte requested |
| rdata_o | output | 8 | Read byte |
| rd_idx_o | output | LEN_W | Offset of the read byte |
| rd_vld_o | output | 1 | Read byte valid |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse |
| err_code_o | output | 2 | Cause of last failed attempt: 1 enable, 2 reply, 3 error |
| buf_clr_o | output | 1 | Clear engine buffer |
| buf_we_o | output | 1 | Write engine buffer slot |
| buf_idx_o | output | IDX_W | Buffer slot index |
| buf_wdata_o | output | 8 | Buffer write byte |
| buf_rdata_i | input | 8 | Buffer byte at `buf_idx_o` |
| addr_lo_o | output | 8 | Address bits 7:0 |
| addr_mid_o | output | 8 | Address bits 15:8 |
| addr_hi_o | output | 4 | Address bits 19:16 |
| cmd_o | output | 8 | Command word |
| launch_o | output | 1 | Sets the engine enable bit |
| en_busy_i | input | 1 | Engine enable bit, self-clearing |
| reply_i | input | 1 | Reply-received flag |
| reply_clr_o | output | 1 | Write-one clear of reply flag |
| acc_err_i | input | 1 | Access-error flag |
| acc_err_clr_o | output | 1 | Write-one clear of error flag |
| rply_stat_i | input | 4 | Reply status, nonzero = failure |

## Verification
A corrupted chunk length or address register shows up at the next launch as a wrong command length field or address fields. It also shows up in the sink memory once the write commits. A broken retry counter shows as an eleventh launch of the same chunk, or as an error pulse after too few launches. Both are visible within one attempt, about a hundred cycles at the bench's tick ratio. A wrong state around reply handling appears the same cycle as a clear pulse with no flag set, or as read strobes before a successful reply.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_FILL, S_LAUNCH, S_WAIT_EN, S_WAIT_RPLY, S_CHECK, S_COPY, S_NEXT
  } seq_state_e;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_EN   = 2'd1;
  localparam logic [1:0] ERR_RPLY = 2'd2;
  localparam logic [1:0] ERR_ACC  = 2'd3;

  localparam int ADDR_W = 20;
  localparam logic CMD_NATIVE = 1'b1;
endpackage

// File: rtl/aux_tick_gen.sv
module aux_tick_gen #(
  parameter int TICK_DIV = 24000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_W'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i)             cnt_q <= '0;
    else if (tick_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/aux_cmd_pack.sv
module aux_cmd_pack
  import aux_seq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  input  logic              rd_i,
  output logic [7:0]        addr_lo_o,
  output logic [7:0]        addr_mid_o,
  output logic [3:0]        addr_hi_o,
  output logic [7:0]        cmd_o
);
  logic [3:0] len_fld;

  generate
    if (IDX_W < 4) begin : g_narrow
      assign len_fld = {{(4 - IDX_W){1'b0}}, last_idx_i};
    end else begin : g_full
      assign len_fld = last_idx_i[3:0];
    end
  endgenerate

  assign addr_lo_o  = addr_i[7:0];
  assign addr_mid_o = addr_i[15:8];
  assign addr_hi_o  = addr_i[19:16];
  assign cmd_o      = {len_fld, CMD_NATIVE, 2'b00, rd_i};
endmodule

// File: rtl/aux_xfer_seq.sv
module aux_xfer_seq
  import aux_seq_pkg::*;
#(
  parameter int LEN_W     = 10,
  parameter int CHUNK_MAX = 16,
  parameter int MAX_TRIES = 10,
  parameter int TICK_DIV  = 24000,
  parameter int EN_TMO    = 20,
  parameter int RPLY_TMO  = 10,
  localparam int IDX_W    = $clog2(CHUNK_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [19:0]       addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [7:0]        wdata_i,
  output logic [LEN_W-1:0]  wbyte_idx_o,
  output logic [7:0]        rdata_o,
  output logic [LEN_W-1:0]  rd_idx_o,
  output logic              rd_vld_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic              buf_clr_o,
  output logic              buf_we_o,
  output logic [IDX_W-1:0]  buf_idx_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i,
  output logic [7:0]        addr_lo_o,
  output logic [7:0]        addr_mid_o,
  output logic [3:0]        addr_hi_o,
  output logic [7:0]        cmd_o,
  output logic              launch_o,
  input  logic              en_busy_i,
  input  logic              reply_i,
  output logic              reply_clr_o,
  input  logic              acc_err_i,
  output logic              acc_err_clr_o,
  input  logic [3:0]        rply_stat_i
);
  localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam int TMO_W = $clog2(((EN_TMO > RPLY_TMO) ? EN_TMO : RPLY_TMO) + 1);

  seq_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, off_q, chunk_len;
  logic [IDX_W-1:0]  bidx_q, last_idx;
  logic [TRY_W-1:0]  tries_q;
  logic              rd_q, done_q, err_q;
  logic [1:0]        code_q;
  logic              tick, tmo_restart, tmo_exp;
  logic [TMO_W-1:0]  tmo_limit;
  logic              fail_now;
  logic [1:0]        fail_code;

  // chunk sizing
  assign chunk_len = (rem_q >= LEN_W'(CHUNK_MAX)) ? LEN_W'(CHUNK_MAX) : rem_q;
  assign last_idx  = (rem_q >= LEN_W'(CHUNK_MAX)) ? IDX_W'(CHUNK_MAX - 1)
                                                  : IDX_W'(rem_q - 1'b1);

  aux_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign tmo_restart = (st_q == S_LAUNCH) || (st_q == S_WAIT_EN && !en_busy_i);
  assign tmo_limit   = (st_q == S_WAIT_EN) ? TMO_W'(EN_TMO) : TMO_W'(RPLY_TMO);

  aux_wait_timer #(.W(TMO_W)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(tmo_restart), .tick_i(tick),
    .limit_i(tmo_limit), .expired_o(tmo_exp)
  );

  aux_cmd_pack #(.IDX_W(IDX_W)) u_cmd (
    .addr_i(addr_q), .last_idx_i(last_idx), .rd_i(rd_q),
    .addr_lo_o(addr_lo_o), .addr_mid_o(addr_mid_o), .addr_hi_o(addr_hi_o),
    .cmd_o(cmd_o)
  );

  // attempt failure classification
  always_comb begin
    fail_now  = 1'b0;
    fail_code = ERR_NONE;
    unique case (st_q)
      S_WAIT_EN: if (en_busy_i && tmo_exp) begin
        fail_now = 1'b1; fail_code = ERR_EN;
      end
      S_WAIT_RPLY: if (!reply_i && tmo_exp) begin
        fail_now = 1'b1; fail_code = ERR_RPLY;
      end
      S_CHECK: if (acc_err_i || (rply_stat_i != 4'd0)) begin
        fail_now = 1'b1; fail_code = ERR_ACC;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      off_q   <= '0;
      bidx_q  <= '0;
      tries_q <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (fail_now) begin
        code_q <= fail_code;
        if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
          err_q <= 1'b1;
          st_q  <= S_IDLE;
        end else begin
          tries_q <= tries_q + 1'b1;
          st_q    <= S_CLR;
        end
      end else begin
        unique case (st_q)
          S_IDLE: if (start_i) begin
            addr_q  <= addr_i;
            rem_q   <= len_i;
            off_q   <= '0;
            rd_q    <= rd_i;
            tries_q <= '0;
            code_q  <= ERR_NONE;
            if (len_i == '0) done_q <= 1'b1;
            else             st_q   <= S_CLR;
          end
          S_CLR: begin
            bidx_q <= '0;
            st_q   <= rd_q ? S_LAUNCH : S_FILL;
          end
          S_FILL: begin
            if (bidx_q == last_idx) st_q <= S_LAUNCH;
            else                    bidx_q <= bidx_q + 1'b1;
          end
          S_LAUNCH:    st_q <= S_WAIT_EN;
          S_WAIT_EN:   if (!en_busy_i) st_q <= S_WAIT_RPLY;
          S_WAIT_RPLY: if (reply_i) st_q <= S_CHECK;
          S_CHECK: begin
            bidx_q <= '0;
            st_q   <= rd_q ? S_COPY : S_NEXT;
          end
          S_COPY: begin
            if (bidx_q == last_idx) st_q <= S_NEXT;
            else                    bidx_q <= bidx_q + 1'b1;
          end
          S_NEXT: begin
            addr_q  <= addr_q + ADDR_W'(chunk_len);
            off_q   <= off_q + chunk_len;
            rem_q   <= rem_q - chunk_len;
            tries_q <= '0;
            if (rem_q == chunk_len) begin
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end else begin
              st_q <= S_CLR;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign busy_o        = (st_q != S_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign err_code_o    = code_q;
  assign buf_clr_o     = (st_q == S_CLR);
  assign buf_we_o      = (st_q == S_FILL);
  assign buf_idx_o     = bidx_q;
  assign buf_wdata_o   = wdata_i;
  assign wbyte_idx_o   = off_q + LEN_W'(bidx_q);
  assign launch_o      = (st_q == S_LAUNCH);
  assign reply_clr_o   = (st_q == S_WAIT_RPLY) && reply_i;
  assign acc_err_clr_o = (st_q == S_CHECK) && acc_err_i;
  assign rd_vld_o      = (st_q == S_COPY);
  assign rdata_o       = buf_rdata_i;
  assign rd_idx_o      = off_q + LEN_W'(bidx_q);
endmodule

// File: rtl/aux_xfer_seq_chk.sv
module aux_xfer_seq_chk #(
  parameter int MAX_TRIES = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       launch_o,
  input logic       buf_clr_o,
  input logic       buf_we_o,
  input logic [7:0] cmd_o,
  input logic [7:0] addr_lo_o,
  input logic [7:0] addr_mid_o,
  input logic [3:0] addr_hi_o,
  input logic       reply_i,
  input logic       reply_clr_o,
  input logic       acc_err_i,
  input logic       acc_err_clr_o,
  input logic       rd_vld_o
);
  logic        clr_seen_q;
  logic [4:0]  we_cnt_q;
  logic [19:0] prev_addr_q;
  logic [7:0]  launch_cnt_q;
  logic [19:0] cur_addr;

  assign cur_addr = {addr_hi_o, addr_mid_o, addr_lo_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_seen_q   <= 1'b0;
      we_cnt_q     <= '0;
      prev_addr_q  <= '0;
      launch_cnt_q <= '0;
    end else begin
      prev_addr_q <= cur_addr;
      if (buf_clr_o) begin
        clr_seen_q <= 1'b1;
        we_cnt_q   <= '0;
      end else begin
        if (launch_o) clr_seen_q <= 1'b0;
        if (buf_we_o) we_cnt_q <= we_cnt_q + 1'b1;
      end
      if ((start_i && !busy_o) || (cur_addr != prev_addr_q)) launch_cnt_q <= '0;
      else if (launch_o) launch_cnt_q <= launch_cnt_q + 1'b1;
    end
  end

  assert_pulse_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  assert_end_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
  assert_clr_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> clr_seen_q);
  assert_wr_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o && !cmd_o[0]) |-> (we_cnt_q == ({1'b0, cmd_o[7:4]} + 5'd1)));
  assert_try_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (launch_cnt_q < 8'(MAX_TRIES)));
  assert_rply_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_clr_o |-> reply_i);
  assert_err_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_clr_o |-> acc_err_i);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!launch_o && !rd_vld_o));
endmodule

bind aux_xfer_seq aux_xfer_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (.*);

// File: tb/aux_xfer_seq_tb_top.sv
module aux_xfer_seq_tb_top;
  localparam int LEN_W = 10;
  localparam int M_OK = 0, M_EN = 1, M_RP = 2, M_ACC = 3, M_ST = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, rd_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic [7:0] wdata_i;
  logic [LEN_W-1:0] wbyte_idx_o, rd_idx_o;
  logic [7:0] rdata_o, buf_wdata_o, buf_rdata_i, addr_lo_o, addr_mid_o, cmd_o;
  logic rd_vld_o, busy_o, done_o, err_o, buf_clr_o, buf_we_o, launch_o;
  logic reply_clr_o, acc_err_clr_o;
  logic [1:0] err_code_o;
  logic [3:0] buf_idx_o, addr_hi_o;
  logic en_busy, reply_f, err_f;
  logic [3:0] stat_f;

  always #10 clk_i = ~clk_i;

  aux_xfer_seq #(.LEN_W(LEN_W), .TICK_DIV(4)) dut_i (
    .clk_i, .rst_ni, .start_i, .rd_i, .addr_i, .len_i, .wdata_i, .wbyte_idx_o,
    .rdata_o, .rd_idx_o, .rd_vld_o, .busy_o, .done_o, .err_o, .err_code_o,
    .buf_clr_o, .buf_we_o, .buf_idx_o, .buf_wdata_o, .buf_rdata_i,
    .addr_lo_o, .addr_mid_o, .addr_hi_o, .cmd_o, .launch_o,
    .en_busy_i(en_busy), .reply_i(reply_f), .reply_clr_o,
    .acc_err_i(err_f), .acc_err_clr_o, .rply_stat_i(stat_f)
  );

  // behavioural sink + engine
  logic [7:0] sink [int];
  logic [7:0] ebuf [16];
  logic [7:0] wsrc [1024];
  logic [7:0] rcv  [1024];
  int la_addr [64];
  int la_cmd  [64];
  int n_la = 0, n_rd = 0, n_eclr = 0, att_total = 0, att_base = 0;
  int fail_n = 0, fail_mode = M_OK, mode_cur = M_OK;
  int en_cnt = 0, rp_cnt = 0, l_addr = 0, l_cmd = 0;
  logic rp_pend = 1'b0;
  int checks = 0, fails = 0, cyc = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] mem_rd(input int a);
    if (sink.exists(a)) return sink[a];
    return pat(a);
  endfunction

  assign buf_rdata_i = ebuf[buf_idx_o];
  assign wdata_i     = wsrc[wbyte_idx_o];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_busy <= 1'b0; reply_f <= 1'b0; err_f <= 1'b0; stat_f <= 4'd0;
      for (int i = 0; i < 16; i++) ebuf[i] <= 8'h00;
    end else begin
      cyc = cyc + 1;
      if (buf_clr_o) for (int i = 0; i < 16; i++) ebuf[i] <= 8'h00;
      if (buf_we_o) ebuf[buf_idx_o] <= buf_wdata_o;
      if (rd_vld_o) begin rcv[rd_idx_o] = rdata_o; n_rd = n_rd + 1; end
      if (acc_err_clr_o) n_eclr = n_eclr + 1;
      if (launch_o) begin
        if (n_la < 64) begin
          la_addr[n_la] = {addr_hi_o, addr_mid_o, addr_lo_o};
          la_cmd[n_la]  = cmd_o;
        end
        n_la = n_la + 1;
        mode_cur = ((att_total - att_base) < fail_n) ? fail_mode : M_OK;
        att_total = att_total + 1;
        l_addr = {addr_hi_o, addr_mid_o, addr_lo_o};
        l_cmd  = cmd_o;
        en_busy <= 1'b1; en_cnt = 2; stat_f <= 4'd0;
      end else if (en_busy && mode_cur != M_EN) begin
        if (en_cnt == 0) begin en_busy <= 1'b0; rp_pend = 1'b1; rp_cnt = 3; end
        else en_cnt = en_cnt - 1;
      end else if (rp_pend && mode_cur != M_RP) begin
        if (rp_cnt == 0) begin
          rp_pend = 1'b0;
          reply_f <= 1'b1;
          if (mode_cur == M_ACC) err_f <= 1'b1;
          else if (mode_cur == M_ST) stat_f <= 4'd2;
          else if (l_cmd[0]) begin
            for (int i = 0; i <= l_cmd[7:4]; i++) ebuf[i] <= mem_rd(l_addr + i);
          end else begin
            for (int i = 0; i <= l_cmd[7:4]; i++) sink[l_addr + i] = ebuf[i];
          end
        end else rp_cnt = rp_cnt - 1;
      end
      if (reply_clr_o) reply_f <= 1'b0;
      if (acc_err_clr_o) err_f <= 1'b0;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int mode, input int n);
    att_base = att_total; fail_mode = mode; fail_n = n;
    n_la = 0; n_rd = 0; n_eclr = 0;
  endtask

  int got_done, got_err;
  task automatic xfer(input logic rd, input int a, input int len);
    int guard;
    got_done = 0; got_err = 0; guard = 0;
    @(negedge clk_i);
    rd_i = rd; addr_i = 20'(a); len_i = LEN_W'(len); start_i = 1'b1;
    do begin
      @(negedge clk_i);
      start_i = 1'b0;
      guard = guard + 1;
      if (done_o) got_done = 1;
      if (err_o) got_err = 1;
    end while (!got_done && !got_err && guard < 5000);
    if (guard >= 5000) chk(1'b0, "watchdog", guard, 0);
  endtask

  initial begin : main
    int ok;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(!busy_o && !done_o && !err_o && !launch_o, "R11", {busy_o, done_o, err_o, launch_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !launch_o, "R11", {busy_o, launch_o}, 0);

    // R5/R4/R3 single write
    for (int i = 0; i < 1024; i++) wsrc[i] = 8'(8'hA0 + i);
    cfg(M_OK, 0);
    xfer(1'b0, 'h12345, 5);
    chk(got_done == 1 && !busy_o, "R12", got_done, 1);
    chk(n_la == 1, "R1", n_la, 1);
    chk(la_cmd[0] == 'h48, "R4", la_cmd[0], 'h48);
    chk(la_addr[0] == 'h12345, "R3", la_addr[0], 'h12345);
    ok = 1;
    for (int i = 0; i < 5; i++) if (mem_rd('h12345 + i) != wsrc[i]) ok = 0;
    chk(ok == 1, "R5", ok, 1);

    // R1 exact two-chunk write
    for (int i = 0; i < 1024; i++) wsrc[i] = 8'(i * 3 + 1);
    cfg(M_OK, 0);
    xfer(1'b0, 'h00200, 32);
    chk(n_la == 2 && la_addr[1] == 'h00210, "R1", la_addr[1], 'h00210);
    chk(la_cmd[0] == 'hF8 && la_cmd[1] == 'hF8, "R4", la_cmd[1], 'hF8);
    ok = 1;
    for (int i = 0; i < 32; i++) if (mem_rd('h200 + i) != wsrc[i]) ok = 0;
    chk(ok == 1, "R5", ok, 1);

    // R1/R6 multi-chunk read across a 16-bit boundary
    cfg(M_OK, 0);
    xfer(1'b1, 'h0FFF8, 37);
    chk(got_done == 1, "R6", got_done, 1);
    chk(n_la == 3 && la_addr[1] == 'h10008 && la_addr[2] == 'h10018, "R1", la_addr[2], 'h10018);
    chk(la_cmd[0] == 'hF9 && la_cmd[2] == 'h49, "R4", la_cmd[2], 'h49);
    chk(la_addr[1] / 65536 == 1, "R3", la_addr[1] / 65536, 1);
    ok = 1;
    for (int i = 0; i < 37; i++) if (rcv[i] != mem_rd('h0FFF8 + i)) ok = 0;
    chk(ok == 1 && n_rd == 37, "R6", n_rd, 37);

    // R10 zero length
    cfg(M_OK, 0);
    xfer(1'b1, 'h00010, 0);
    chk(got_done == 1 && n_la == 0, "R10", n_la, 0);

    // R9 access error retried, reads withheld until success
    cfg(M_ACC, 3);
    xfer(1'b1, 'h00400, 8);
    chk(got_done == 1 && n_la == 4, "R2", n_la, 4);
    chk(n_eclr == 3, "R9", n_eclr, 3);
    chk(n_rd == 8 && rcv[7] == mem_rd('h407), "R6", n_rd, 8);

    // R9 nonzero reply status
    cfg(M_ST, 2);
    xfer(1'b0, 'h00500, 3);
    chk(got_done == 1 && n_la == 3, "R9", n_la, 3);

    // R7 enable timeout on every attempt
    cfg(M_EN, 100);
    xfer(1'b0, 'h00600, 4);
    chk(got_err == 1 && n_la == 10, "R2", n_la, 10);
    chk(err_code_o == 2'd1, "R7", err_code_o, 1);

    // R8 reply timeout, later chunk never issued
    cfg(M_RP, 100);
    xfer(1'b1, 'h00700, 20);
    chk(got_err == 1 && n_la == 10 && la_addr[9] == 'h00700, "R2", n_la, 10);
    chk(err_code_o == 2'd2, "R8", err_code_o, 2);
    chk(n_rd == 0, "R6", n_rd, 0);

    // R9 access error exhausts retries
    cfg(M_ACC, 100);
    xfer(1'b0, 'h00800, 2);
    chk(got_err == 1 && err_code_o == 2'd3, "R9", err_code_o, 3);
    chk(mem_rd('h800) == pat('h800), "R9", mem_rd('h800), pat('h800));

    // recovery after error: clean transfer still works
    cfg(M_OK, 0);
    xfer(1'b1, 'h00010, 1);
    chk(got_done == 1 && rcv[0] == mem_rd('h10), "R6", rcv[0], mem_rd('h10));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    wait (cyc > 150000);
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule